// File: doc/BRIEF.md
# Programmable Raster Timing Controller

This block produces the raster timing for a television or monitor output. Two counters track the pixel position within a line and the line position within a frame. From these counts and a set of programmable timing values the block drives horizontal and vertical sync, a horizontal blanking flag, an active-video window and a one-cycle line interrupt at a scan line chosen by software. Frame-memory fetch, encoding, scaling and colour conversion are handled elsewhere and are not part of this block.

The block has two sync modes. In master mode it wraps its own counters at the programmed line length and frame height. In slave mode it locks those counters to rising edges on external sync inputs. It runs either from a single pixel clock, where the counters advance every cycle, or from a double-rate clock with a qualifier strobe, where the counters advance only on qualified cycles. Timing values are loaded through a simple write port. A write goes into a shadow copy, and the shadow copy becomes the working set at the next frame start, so a frame never shows a mix of old and new timing.

There is no data stream at this boundary. Every pin is a plain control or status signal, so the block has no valid/ready handshake and no back-pressure.

Top module: `raster_timing_ctrl`

## Requirements
- R1: While reset is asserted, and on the first sample after it, the pixel and line counts are zero and all timing values hold their parameter defaults.
- R2: A "tick" is a cycle in which the counters may advance. On each tick in master mode the pixel count increments. When the pixel count equals line length minus one, it wraps to 0 and the line count increments. When the line count equals frame height minus one, it wraps to 0. Programmed line length and frame height are at least 2.
- R3: hsync_o is high exactly when the pixel count is below the horizontal sync width. vsync_o is high exactly when the line count is below the vertical sync width, so line 0 begins at the leading edge of vertical sync.
- R4: hblank_o is high exactly when the pixel count is at or above the blanking start value.
- R5: active_o is high exactly when the pixel count lies in [active-x first, active-x last] and the line count lies in [active-y first, active-y last]. Both ends of both ranges are included.
- R6: line_irq_o is a single-cycle pulse. It is raised in the first cycle in which the line count equals the interrupt line and the pixel count is zero, and it is not raised again while the counters hold that position.
- R7: Control bit 1 set selects double-clock mode, where a tick is a cycle with clk_qual high and the counters stay unchanged on any other cycle. With bit 1 clear, every cycle is a tick and clk_qual has no effect.
- R8: A write stores reg_wdata in a shadow register. All shadow values become active together at the next frame start. Address map: 0 active-x first, 1 active-x last, 2 active-y first, 3 active-y last, 4 interrupt line, 5 blanking start, 6 line length, 7 frame height, 8 hsync width, 9 vsync width, 10 control. A shadow write in the same cycle as a frame start becomes active one frame later.
- R9: Control bit 0 set selects slave mode. On a tick, a rising edge on ext_vsync_i sets both counts to zero and is the frame start. On a tick without that edge, a rising edge on ext_hsync_i sets the pixel count to zero and advances the line count with the R2 wrap. On a tick with neither edge, the counters advance as in R2 but do not load the shadow values. Edges are judged against the input levels seen on the previous tick.
- R10: In master mode the external sync inputs have no effect on the counters or the outputs, and the frame start is the wrap from the last pixel of the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (or double-rate clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_qual | input | 1 | Qualifier strobe, used in double-clock mode |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 13 | Register write data |
| ext_hsync_i | input | 1 | External horizontal sync, used in slave mode |
| ext_vsync_i | input | 1 | External vertical sync, used in slave mode |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking |
| active_o | output | 1 | Active-video window |
| line_irq_o | output | 1 | Line interrupt pulse |
| pixel_o | output | 13 | Current pixel count |
| line_o | output | 13 | Current line count |

## Verification
On every cycle the assertions check the following counter properties. A master-mode tick advances the pixel count by one. A cycle without a tick leaves both counts unchanged. The pixel count stays below the line length. Vertical sync rises only at line 0. The interrupt is one cycle wide and falls at pixel zero.

The decoded outputs are checked only by the bench, against an arithmetic model that it updates every cycle. These outputs are the window edges, the blanking and sync widths and the exact line of the interrupt. The bench scenarios also cover the behaviour that depends on history. In particular they show that a shadow write does not take effect until the next frame, that a stalled double-clock position does not fire the interrupt again, and that external sync edges realign the counters in slave mode.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CW = 13;
  localparam int AW = 4;

  typedef logic [CW-1:0] coord_t;

  typedef enum logic [AW-1:0] {
    A_XFIRST = 4'd0,
    A_XLAST  = 4'd1,
    A_YFIRST = 4'd2,
    A_YLAST  = 4'd3,
    A_IRQLN  = 4'd4,
    A_BLANK  = 4'd5,
    A_LINELEN = 4'd6,
    A_FRAMEHT = 4'd7,
    A_HSW    = 4'd8,
    A_VSW    = 4'd9,
    A_CTRL   = 4'd10
  } reg_addr_e;

  typedef struct packed {
    coord_t x_first;
    coord_t x_last;
    coord_t y_first;
    coord_t y_last;
    coord_t irq_line;
    coord_t blank_start;
    coord_t line_len;
    coord_t frame_ht;
    coord_t hsync_w;
    coord_t vsync_w;
    logic   slave;
    logic   dbl_clk;
  } timing_cfg_t;
endpackage

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import rtc_pkg::*;
#(
  parameter timing_cfg_t RESET_CFG = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  coord_t         wr_data,
  input  logic           load,
  output timing_cfg_t    cfg
);
  timing_cfg_t shadow_q;
  timing_cfg_t active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RESET_CFG;
      active_q <= RESET_CFG;
    end else begin
      // load takes the shadow value from before any same-cycle write
      if (load) active_q <= shadow_q;
      if (wr_en) begin
        case (wr_addr)
          A_XFIRST:  shadow_q.x_first     <= wr_data;
          A_XLAST:   shadow_q.x_last      <= wr_data;
          A_YFIRST:  shadow_q.y_first     <= wr_data;
          A_YLAST:   shadow_q.y_last      <= wr_data;
          A_IRQLN:   shadow_q.irq_line    <= wr_data;
          A_BLANK:   shadow_q.blank_start <= wr_data;
          A_LINELEN: shadow_q.line_len    <= wr_data;
          A_FRAMEHT: shadow_q.frame_ht    <= wr_data;
          A_HSW:     shadow_q.hsync_w     <= wr_data;
          A_VSW:     shadow_q.vsync_w     <= wr_data;
          A_CTRL: begin
            shadow_q.slave   <= wr_data[0];
            shadow_q.dbl_clk <= wr_data[1];
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg = active_q;
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   slave,
  input  logic   ext_hs,
  input  logic   ext_vs,
  input  coord_t line_len,
  input  coord_t frame_ht,
  output coord_t pixel,
  output coord_t line,
  output logic   frame_start,
  output logic   fresh
);
  coord_t px_q, ln_q, ln_next;
  logic   hs_prev, vs_prev, hs_edge, vs_edge, px_last, ln_last, fresh_q;

  // edges are judged against the level seen on the previous tick
  assign hs_edge = slave & ext_hs & ~hs_prev;
  assign vs_edge = slave & ext_vs & ~vs_prev;
  assign px_last = (px_q == line_len - 1'b1);
  assign ln_last = (ln_q == frame_ht - 1'b1);
  assign ln_next = ln_last ? '0 : ln_q + 1'b1;
  assign frame_start = tick & (slave ? vs_edge : (px_last & ln_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q    <= '0;
      ln_q    <= '0;
      hs_prev <= 1'b0;
      vs_prev <= 1'b0;
      fresh_q <= 1'b1;
    end else begin
      fresh_q <= tick;
      if (tick) begin
        hs_prev <= ext_hs;
        vs_prev <= ext_vs;
        if (vs_edge) begin
          px_q <= '0;
          ln_q <= '0;
        end else if (hs_edge || px_last) begin
          px_q <= '0;
          ln_q <= ln_next;
        end else begin
          px_q <= px_q + 1'b1;
        end
      end
    end
  end

  assign pixel = px_q;
  assign line  = ln_q;
  assign fresh = fresh_q;
endmodule

// File: rtl/rtc_decode.sv
module rtc_decode
  import rtc_pkg::*;
(
  input  coord_t pixel,
  input  coord_t line,
  input  logic   fresh,
  input  coord_t x_first,
  input  coord_t x_last,
  input  coord_t y_first,
  input  coord_t y_last,
  input  coord_t irq_line,
  input  coord_t blank_start,
  input  coord_t hsync_w,
  input  coord_t vsync_w,
  output logic   hsync,
  output logic   vsync,
  output logic   hblank,
  output logic   active,
  output logic   irq
);
  logic in_x, in_y;

  always_comb begin
    in_x   = (pixel >= x_first) && (pixel <= x_last);
    in_y   = (line >= y_first) && (line <= y_last);
    active = in_x && in_y;
    hsync  = pixel < hsync_w;
    vsync  = line < vsync_w;
    hblank = pixel >= blank_start;
    // fresh marks the first cycle at a newly reached position
    irq    = fresh && (pixel == '0) && (line == irq_line);
  end
endmodule

// File: rtl/raster_timing_ctrl.sv
module raster_timing_ctrl
  import rtc_pkg::*;
#(
  parameter int DEF_LINE_LEN = 32,
  parameter int DEF_FRAME_HT = 12,
  parameter int DEF_X_FIRST  = 4,
  parameter int DEF_X_LAST   = 27,
  parameter int DEF_Y_FIRST  = 2,
  parameter int DEF_Y_LAST   = 10,
  parameter int DEF_BLANK    = 28,
  parameter int DEF_IRQ_LINE = 11,
  parameter int DEF_HSYNC_W  = 3,
  parameter int DEF_VSYNC_W  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_qual,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  input  logic          ext_hsync_i,
  input  logic          ext_vsync_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          active_o,
  output logic          line_irq_o,
  output logic [CW-1:0] pixel_o,
  output logic [CW-1:0] line_o
);
  localparam timing_cfg_t RESET_CFG = '{
    x_first:     coord_t'(DEF_X_FIRST),
    x_last:      coord_t'(DEF_X_LAST),
    y_first:     coord_t'(DEF_Y_FIRST),
    y_last:      coord_t'(DEF_Y_LAST),
    irq_line:    coord_t'(DEF_IRQ_LINE),
    blank_start: coord_t'(DEF_BLANK),
    line_len:    coord_t'(DEF_LINE_LEN),
    frame_ht:    coord_t'(DEF_FRAME_HT),
    hsync_w:     coord_t'(DEF_HSYNC_W),
    vsync_w:     coord_t'(DEF_VSYNC_W),
    slave:       1'b0,
    dbl_clk:     1'b0
  };

  timing_cfg_t cfg;
  logic        tick, frame_start, fresh;
  coord_t      pixel, line;

  assign tick = ~cfg.dbl_clk | clk_qual;

  rtc_cfg_regs #(.RESET_CFG(RESET_CFG)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .load(frame_start), .cfg(cfg)
  );

  rtc_counters i_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slave(cfg.slave),
    .ext_hs(ext_hsync_i), .ext_vs(ext_vsync_i),
    .line_len(cfg.line_len), .frame_ht(cfg.frame_ht),
    .pixel(pixel), .line(line), .frame_start(frame_start), .fresh(fresh)
  );

  rtc_decode i_dec (
    .pixel(pixel), .line(line), .fresh(fresh),
    .x_first(cfg.x_first), .x_last(cfg.x_last),
    .y_first(cfg.y_first), .y_last(cfg.y_last),
    .irq_line(cfg.irq_line), .blank_start(cfg.blank_start),
    .hsync_w(cfg.hsync_w), .vsync_w(cfg.vsync_w),
    .hsync(hsync_o), .vsync(vsync_o), .hblank(hblank_o),
    .active(active_o), .irq(line_irq_o)
  );

  assign pixel_o = pixel;
  assign line_o  = line;
endmodule

// File: rtl/raster_timing_ctrl_chk.sv
module raster_timing_ctrl_chk
  import rtc_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   tick,
  input logic   slave,
  input coord_t line_len,
  input coord_t pixel,
  input coord_t line,
  input logic   vsync,
  input logic   irq
);
  // R2
  px_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !slave && (pixel != line_len - 1'b1)) |=> (pixel == $past(pixel) + 1'b1));

  // R2
  px_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pixel < line_len);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pixel) && $stable(line)));

  // R3
  vsync_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (line == '0));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pixel == '0));
endmodule

bind raster_timing_ctrl raster_timing_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .slave(cfg.slave),
  .line_len(cfg.line_len), .pixel(pixel), .line(line),
  .vsync(vsync_o), .irq(line_irq_o)
);

// File: tb/test_raster_timing_ctrl.sv
module test_raster_timing_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_qual = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [12:0] reg_wdata = '0;
  logic        ext_hsync_i = 1'b0;
  logic        ext_vsync_i = 1'b0;
  logic        hsync_o, vsync_o, hblank_o, active_o, line_irq_o;
  logic [12:0] pixel_o, line_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_ctrl i_raster_timing_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_qual(clk_qual), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ext_hsync_i(ext_hsync_i), .ext_vsync_i(ext_vsync_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o),
    .active_o(active_o), .line_irq_o(line_irq_o),
    .pixel_o(pixel_o), .line_o(line_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // model: index = register address
  int m_cur[11] = '{4, 27, 2, 10, 11, 28, 32, 12, 3, 2, 0};
  int m_sh[11]  = '{4, 27, 2, 10, 11, 28, 32, 12, 3, 2, 0};
  int m_px = 0, m_ln = 0;
  bit m_moved = 1'b1, m_phs = 1'b0, m_pvs = 1'b0, m_loaded = 1'b0;
  string t_cnt = "R1";
  string t_hb  = "R4";

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit e_irq;
    bit e_act;
    e_act = (m_px >= m_cur[0]) && (m_px <= m_cur[1]) && (m_ln >= m_cur[2]) && (m_ln <= m_cur[3]);
    e_irq = m_moved && (m_px == 0) && (m_ln == m_cur[4]);
    chk(int'(pixel_o) == m_px, t_cnt, "pixel", int'(pixel_o), m_px);
    chk(int'(line_o) == m_ln, t_cnt, "line", int'(line_o), m_ln);
    chk(hsync_o == (m_px < m_cur[8]), "R3", "hsync", hsync_o, int'(m_px < m_cur[8]));
    chk(vsync_o == (m_ln < m_cur[9]), "R3", "vsync", vsync_o, int'(m_ln < m_cur[9]));
    chk(hblank_o == (m_px >= m_cur[5]), t_hb, "hblank", hblank_o, int'(m_px >= m_cur[5]));
    chk(active_o == e_act, "R5", "active", active_o, e_act);
    chk(line_irq_o == e_irq, "R6", "irq", line_irq_o, e_irq);
  endtask

  task automatic load_cfg();
    for (int k = 0; k < 11; k++) m_cur[k] = m_sh[k];
    m_loaded = 1'b1;
  endtask

  task automatic natural_step(bit slave);
    if (m_px == m_cur[6] - 1) begin
      m_px = 0;
      if (m_ln == m_cur[7] - 1) begin
        m_ln = 0;
        if (!slave) load_cfg();
      end else m_ln++;
    end else m_px++;
  endtask

  task automatic advance(bit q, bit hs, bit vs);
    bit tick, slave, hs_e, vs_e;
    slave = m_cur[10][0];
    tick = m_cur[10][1] ? q : 1'b1;
    if (tick) begin
      hs_e = slave && hs && !m_phs;
      vs_e = slave && vs && !m_pvs;
      if (vs_e) begin
        m_px = 0;
        m_ln = 0;
        load_cfg();
      end else if (hs_e) begin
        m_px = 0;
        m_ln = (m_ln == m_cur[7] - 1) ? 0 : m_ln + 1;
      end else natural_step(slave);
      m_phs = hs;
      m_pvs = vs;
    end
    m_moved = tick;
  endtask

  task automatic step(bit q, bit hs, bit vs, bit we, int a, int d);
    check_all();
    clk_qual = q;
    ext_hsync_i = hs;
    ext_vsync_i = vs;
    reg_we = we;
    reg_addr = 4'(a);
    reg_wdata = 13'(d);
    if (rst_n) begin
      advance(q, hs, vs);
      if (we) m_sh[a] = d;
    end
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    step(1'b1, 1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic wait_frame();
    m_loaded = 1'b0;
    while (!m_loaded) step(1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_up();
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0);

    // configuration A: single clock, master
    t_cnt = "R2";
    wr(0, 2); wr(1, 6); wr(2, 1); wr(3, 3); wr(4, 4); wr(5, 8);
    wr(6, 10); wr(7, 6); wr(8, 2); wr(9, 1); wr(10, 0);
    wait_frame();

    // R10: external syncs and qualifier toggled randomly in master single-clock mode
    t_cnt = "R10";
    for (int i = 0; i < 130; i++) begin
      bit q, hs, vs;
      q = 1'($urandom);
      hs = 1'($urandom);
      vs = 1'($urandom);
      if (i == 15) begin
        t_hb = "R8";
        step(q, hs, vs, 1'b1, 5, 5);
      end else step(q, hs, vs, 1'b0, 0, 0);
    end
    t_hb = "R4";

    // configuration B: double clock with qualifier
    wr(4, 2); wr(8, 3); wr(10, 2);
    wait_frame();
    t_cnt = "R7";
    for (int i = 0; i < 200; i++) step(((i % 3) != 2) && ((i % 7) != 5), 1'b0, 1'b0, 1'b0, 0, 0);

    // configuration C: slave, single clock
    t_cnt = "R8";
    wr(6, 8); wr(7, 5); wr(4, 2); wr(10, 1);
    wait_frame();
    t_cnt = "R9";
    for (int i = 0; i < 70; i++) begin
      bit hs, vs;
      hs = (i == 3) || (i == 9) || (i == 14) || (i == 30) || (i == 36) || (i == 37);
      vs = (i == 3) || (i == 30) || (i == 50);
      if (i == 20) step(1'b0, hs, vs, 1'b1, 4, 1);
      else step(1'b0, hs, vs, 1'b0, 0, 0);
    end

    finish_up();
  end
endmodule